// File: doc/BRIEF.md
# Banked UART Register Window Decoder

This block sits behind the byte-wide host port of a legacy-compatible UART/IR controller. The host sees only eight offsets. Eight banks of byte registers are folded behind that window. A single select register is shared by every bank and chooses which bank later reads and writes reach. The block decodes each host access and stores the byte in the selected bank. It presents the whole register image, the selected bank and an extended/legacy mode flag to the serial engine and the infrared logic.

Old 16550 driver code runs unchanged. Such code sets the divisor-latch bit, which lands in bank 1, and writes the divisor there. Writing either divisor byte also drops the mode flag back to legacy, without any extra step. The extended mode is entered only by an explicit control-bit write in bank 2. A parameter builds a reduced variant in which the four IR-only banks (4 to 7) hold no storage.

Top module: `uart_bank_window`

## Requirements
- R1: Reset is synchronous and active high. Afterwards the select register reads 00h, bank 0 is selected, `ext_mode` is 0 and every stored register is 00h.
- R2: Offset 3 is the shared select register in every bank. A write to offset 3 from any bank updates it, and a read of offset 3 returns the same value whichever bank is active.
- R3: The selected bank is decoded from the select register as follows. If bit 7 is 0, bank 0 is selected. If bit 7 is 1 and bit 6 is 0, bank 1 is selected. If bits 7 and 6 are both 1, the bank is given by bits 2:0.
- R4: A new bank selection takes effect on the first access after the clock edge that stores the select write.
- R5: A write to offset o (o ≠ 3) changes only that register in the selected bank. The register at the same offset in every other bank is left unchanged. A read returns the stored byte combinationally while `rd_en` is high, and `rdata` is 00h while `rd_en` is low.
- R6: A write to offset 0 or 1 of bank 1 (the divisor bytes) clears `ext_mode` on the next edge. The write clears bit 0 of bank 2 offset 4 and keeps the other bits of that register.
- R7: Bank 2 offset 4 stores the written byte, and its bit 0 is the `ext_mode` flag. Writing a 1 there sets extended mode on the next edge.
- R8: With `IR_BANKS` = 0, banks 4 to 7 read 00h and writes to them are ignored.
- R9: With `IR_BANKS` = 1 (default), banks 4 to 7 store and return bytes like banks 0 to 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 3 | Window offset |
| wdata | input | 8 | Write byte |
| wr_en | input | 1 | Write strobe, committed at the clock edge |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Read byte (00h when rd_en is low) |
| bank_sel | output | 3 | Currently selected bank |
| ext_mode | output | 1 | 1 = extended mode, 0 = 16550-compatible |
| sel_reg | output | 8 | Shared select register value |
| reg_flat | output | 512 | All banks; bank b offset o at bits [(8b+o)*8 +: 8], offset 3 slots read 0 |

## Verification
The window is exercised with writes of different bytes to the same offset in several banks. Reading them back after each bank switch tells correct per-bank decoding apart from aliasing between banks. The select register is written with values from each of the three decode classes: bit 7 clear, divisor-latch form and explicit bank number. Reading offset 3 from each resulting bank shows both the decode and the sharing of the select register. The mode flag is set through bank 2 and then cleared by a divisor write, which separates the automatic legacy fallback from a plain register store. A reduced-variant instance receives the same traffic and separates reserved banks from populated ones.

// File: rtl/uart_bank_window.sv
module uart_bank_window #(
  parameter int DW = 8,
  parameter int AW = 3,
  parameter bit IR_BANKS = 1'b1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [AW-1:0]                addr,
  input  logic [DW-1:0]                wdata,
  input  logic                         wr_en,
  input  logic                         rd_en,
  output logic [DW-1:0]                rdata,
  output logic [AW-1:0]                bank_sel,
  output logic                         ext_mode,
  output logic [DW-1:0]                sel_reg,
  output logic [(1<<(2*AW))*DW-1:0]    reg_flat
);
  localparam int BANKS     = 1 << AW;
  localparam int REGS      = 1 << AW;
  localparam int BANK_BITS = REGS * DW;
  localparam logic [AW-1:0] SEL_OFF  = AW'(3);
  localparam logic [AW-1:0] EXT_OFF  = AW'(4);
  localparam logic [AW-1:0] EXT_BANK = AW'(2);
  localparam logic [AW-1:0] DIV_BANK = AW'(1);
  localparam int FIRST_IR = BANKS / 2;

  logic [DW-1:0] sel_q;
  logic          sel_wr, div_wr;

  assign sel_wr = wr_en && addr == SEL_OFF;
  assign div_wr = wr_en && bank_sel == DIV_BANK && addr <= AW'(1);

  always_ff @(posedge clk) begin
    if (rst)         sel_q <= '0;
    else if (sel_wr) sel_q <= wdata;
  end

  assign bank_sel = !sel_q[DW-1] ? '0 :
                    !sel_q[DW-2] ? DIV_BANK : sel_q[AW-1:0];
  assign sel_reg  = sel_q;

  genvar b;
  generate
    for (b = 0; b < BANKS; b++) begin : g_bank
      if (!IR_BANKS && b >= FIRST_IR) begin : g_rsvd
        assign reg_flat[b*BANK_BITS +: BANK_BITS] = '0;
      end else begin : g_live
        logic [DW-1:0] mem [REGS];
        logic          hit;
        assign hit = wr_en && bank_sel == AW'(b) && addr != SEL_OFF;
        always_ff @(posedge clk) begin
          if (rst) begin
            for (int i = 0; i < REGS; i++) mem[i] <= '0;
          end else if (hit) begin
            mem[addr] <= wdata;
          end else if (b == EXT_BANK && div_wr) begin
            mem[EXT_OFF][0] <= 1'b0;
          end
        end
        for (genvar o = 0; o < REGS; o++) begin : g_out
          assign reg_flat[(b*REGS+o)*DW +: DW] = mem[o];
        end
      end
    end
  endgenerate

  assign ext_mode = reg_flat[(EXT_BANK*REGS+EXT_OFF)*DW];

  logic [DW-1:0] rd_byte;
  assign rd_byte = (addr == SEL_OFF) ? sel_q : reg_flat[{bank_sel, addr}*DW +: DW];
  assign rdata   = rd_en ? rd_byte : '0;

  p_reset_r1: assert property (@(posedge clk) rst |=> (sel_q == '0 && !ext_mode && bank_sel == '0));
  p_sel_write_r2: assert property (@(posedge clk) disable iff (rst)
    sel_wr |=> sel_reg == $past(wdata));
  p_bank_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !sel_wr |=> $stable(bank_sel));
  p_div_legacy_r6: assert property (@(posedge clk) disable iff (rst)
    div_wr |=> !ext_mode);
  p_ext_set_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && bank_sel == EXT_BANK && addr == EXT_OFF && wdata[0]) |=> ext_mode);
  p_rd_idle_r5: assert property (@(posedge clk) disable iff (rst) !rd_en |-> rdata == '0);
  generate
    if (!IR_BANKS) begin : g_rsvd_chk
      p_rsvd_read_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_en && bank_sel >= AW'(FIRST_IR) && addr != SEL_OFF) |-> rdata == '0);
    end
  endgenerate
endmodule

// File: tb/test_uart_bank_window.sv
module test_uart_bank_window;
  logic clk = 0, rst = 1;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0;
  logic wr_en = 0, rd_en = 1;
  logic [7:0] rdata, rdata_l, sel_reg, sel_reg_l;
  logic [2:0] bank_sel, bank_sel_l;
  logic ext_mode, ext_mode_l;
  logic [511:0] reg_flat, reg_flat_l;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  uart_bank_window i_uart_bank_window (.clk, .rst, .addr, .wdata, .wr_en, .rd_en,
    .rdata, .bank_sel, .ext_mode, .sel_reg, .reg_flat);
  uart_bank_window #(.IR_BANKS(1'b0)) i_uart_bank_window_lite (.clk, .rst, .addr, .wdata,
    .wr_en, .rd_en, .rdata(rdata_l), .bank_sel(bank_sel_l), .ext_mode(ext_mode_l),
    .sel_reg(sel_reg_l), .reg_flat(reg_flat_l));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string req);
    @(negedge clk); addr = a; wr_en = 0; #1;
    chk(req, rdata, exp);
  endtask

  // {check, write, addr, wdata, expected}
  localparam int NV = 20;
  localparam logic [20:0] VEC [NV] = '{
    {1'b0,1'b1,3'd3,8'h00,8'h00},
    {1'b0,1'b1,3'd0,8'h11,8'h00},
    {1'b0,1'b1,3'd3,8'h80,8'h00},
    {1'b0,1'b1,3'd0,8'h22,8'h00},
    {1'b1,1'b0,3'd0,8'h00,8'h22},
    {1'b1,1'b0,3'd3,8'h00,8'h80},
    {1'b0,1'b1,3'd3,8'hC2,8'h00},
    {1'b0,1'b1,3'd0,8'h33,8'h00},
    {1'b1,1'b0,3'd3,8'h00,8'hC2},
    {1'b1,1'b0,3'd0,8'h00,8'h33},
    {1'b0,1'b1,3'd3,8'h00,8'h00},
    {1'b1,1'b0,3'd0,8'h00,8'h11},
    {1'b0,1'b1,3'd3,8'hC5,8'h00},
    {1'b0,1'b1,3'd6,8'h5A,8'h00},
    {1'b1,1'b0,3'd6,8'h00,8'h5A},
    {1'b1,1'b0,3'd0,8'h00,8'h00},
    {1'b0,1'b1,3'd3,8'h03,8'h00},
    {1'b1,1'b0,3'd3,8'h00,8'h03},
    {1'b1,1'b0,3'd0,8'h00,8'h11},
    {1'b1,1'b0,3'd6,8'h00,8'h00}
  };

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    chk("R1 sel", sel_reg, 8'h00);
    chk("R1 bank", {5'b0, bank_sel}, 8'h00);
    chk("R1 ext", {7'b0, ext_mode}, 8'h00);
    chk("R1 flat", 8'(|reg_flat), 8'h00);

    // R2 R3 R5 R9: table walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][19]) wr(VEC[i][18:16], VEC[i][15:8]);
      else if (VEC[i][20]) rd(VEC[i][18:16], VEC[i][7:0], "R5 table");
    end

    // R3 decode of three classes
    wr(3'd3, 8'h83); #1; chk("R3 dlab", {5'b0, bank_sel}, 8'h01);
    wr(3'd3, 8'hC7); #1; chk("R3 explicit", {5'b0, bank_sel}, 8'h07);
    wr(3'd3, 8'h47); #1; chk("R3 legacy", {5'b0, bank_sel}, 8'h00);

    // R4: bank unchanged until the edge that stores the select write
    @(negedge clk); addr = 3'd3; wdata = 8'hC6; wr_en = 1; #1;
    chk("R4 before edge", {5'b0, bank_sel}, 8'h00);
    @(posedge clk); #1;
    chk("R4 after edge", {5'b0, bank_sel}, 8'h06);
    @(negedge clk); wr_en = 0;

    // R2: select value identical in every bank
    rd(3'd3, 8'hC6, "R2 bank6");
    wr(3'd3, 8'hC4); rd(3'd3, 8'hC4, "R2 bank4");

    // R8 / R9 at bank 5
    wr(3'd3, 8'hC5); rd(3'd6, 8'h5A, "R9 bank5");
    chk("R8 lite read", rdata_l, 8'h00);
    wr(3'd1, 8'h99); #1;
    chk("R8 lite write", rdata_l, 8'h00);
    chk("R8 lite flat", 8'(|reg_flat_l[4*64 +: 256]), 8'h00);

    // R7 set extended, R6 divisor write clears it
    wr(3'd3, 8'hC2); wr(3'd4, 8'hA5); #1;
    chk("R7 ext set", {7'b0, ext_mode}, 8'h01);
    rd(3'd4, 8'hA5, "R7 stored");
    wr(3'd3, 8'h80); wr(3'd1, 8'h00); #1;
    chk("R6 ext clear", {7'b0, ext_mode}, 8'h00);
    wr(3'd3, 8'hC2); rd(3'd4, 8'hA4, "R6 other bits kept");
    wr(3'd4, 8'h01); wr(3'd3, 8'h80); wr(3'd0, 8'h05); #1;
    chk("R6 low byte clears", {7'b0, ext_mode}, 8'h00);

    // R5: other banks at offset 0 untouched, idle read
    wr(3'd3, 8'h00); rd(3'd0, 8'h11, "R5 bank0 kept");
    @(negedge clk); rd_en = 0; #1; chk("R5 rd idle", rdata, 8'h00);
    rd_en = 1;

    // R1: reset again clears state
    @(negedge clk); rst = 1; @(negedge clk); rst = 0; #1;
    chk("R1 re-reset sel", sel_reg, 8'h00);
    rd(3'd0, 8'h00, "R1 re-reset reg");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule